// File: doc/BRIEF.md
# Write-once tagged memory with deferred readers

This block is a small write-once memory in which every word carries a presence flag. A word is either empty (no value yet) or full (value stored). Producers write each word once; consumers read it with a requester tag. A read of a full word is answered on the next cycle. A read of an empty word is not stalled and not rejected. The requester tag is parked in a linked list that belongs to that word. When the producing write arrives, the block sends the stored value back to every parked requester in turn.

Parked requesters take their storage from one shared pool of entries with a fixed depth. An allocate command returns a contiguous range of words to the empty state. It also releases any requesters still parked on those words. Every response carries the requester tag and the data, so answers for different words may complete in any order. Requests use a valid/ready handshake, and so do responses.

Top module: `isq_mem`

## Requirements
- R1: After the active-low reset `rst_ni` is asserted, every word is empty, `resp_valid_o` and `err_o` are low, and `req_ready_o` is high when no deferred delivery is pending.
- R2: A write (`req_op_i` = 1) to an empty word stores `req_data_i` and marks the word full, so later reads of it return that data.
- R3: A read (`req_op_i` = 0) of a full word, accepted on clock edge k, gives `resp_valid_o` high after edge k, with `resp_tag_o` equal to the read's tag and `resp_data_o` equal to the stored word.
- R4: A read of an empty word is accepted, produces no response and parks its tag on that word.
- R5: A write to an empty word that has parked readers, accepted on edge k, sends one response to each parked reader in the order the reads arrived. The responses carry the written data, and the first is valid after edge k+1. While `resp_ready_i` is high, one response is delivered per cycle.
- R6: While parked responses are still being delivered, `req_ready_o` is low.
- R7: A write to a word that is already full leaves the stored data unchanged and raises `err_o` for exactly one cycle, after the edge that accepted it.
- R8: An allocate (`req_op_i` = 2) empties the words from `req_addr_i` up to `req_addr_i + req_cnt_i - 1`, clipped at the last word. Words outside that range keep their state, and a count of 0 changes nothing.
- R9: An allocate discards the readers parked on the words it empties and returns their entries to the pool. A later write to such a word produces no response.
- R10: When all `POOL_DEPTH` entries are in use, `req_ready_o` is low for a read of an empty word. Reads of full words and writes are still accepted.
- R11: While `resp_valid_o` is high and `resp_ready_i` is low, the response stays valid and its tag and data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when high together with valid |
| req_op_i | input | 2 | 0 read, 1 write, 2 allocate, 3 no operation |
| req_addr_i | input | ADDR_W | Word address, or first word of an allocate range |
| req_cnt_i | input | ADDR_W+1 | Number of words for an allocate |
| req_tag_i | input | TAG_W | Requester tag for a read |
| req_data_i | input | DATA_W | Write data |
| resp_valid_o | output | 1 | Response present |
| resp_ready_i | input | 1 | Consumer takes the response |
| resp_tag_o | output | TAG_W | Tag of the requester being answered |
| resp_data_o | output | DATA_W | Value being returned |
| err_o | output | 1 | One-cycle pulse after a write to a full word |

## Verification
The assertions assume that `req_op_i` carries one of the four defined codes while `req_valid_i` is high. They also assume that a requester may drop a request that has not been accepted. They do not require the request payload to stay stable before acceptance, because `req_ready_o` depends on the addressed word's state. The stimulus changes its inputs only just after a clock edge and samples at the falling edge. It withdraws the one request it deliberately leaves stalled on an exhausted pool. It keeps at most `POOL_DEPTH` readers parked at any time, except at that stall.

// File: rtl/isq_pkg.sv
package isq_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ALLOC = 2'd2,
    OP_NOP   = 2'd3
  } isq_op_e;
endpackage

// File: rtl/isq_presence.sv
module isq_presence #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [WORDS-1:0]  clr_mask_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_full_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [WORDS-1:0]  full_q;
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (clr_mask_i[w])                                full_q[w] <= 1'b0;
        else if (we_i && wr_addr_i == ADDR_W'(w))         full_q[w] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_full_o = full_q[rd_addr_i];
  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/isq_defer_pool.sv
module isq_defer_pool #(
  parameter int ADDR_W = 4,
  parameter int TAG_W  = 4,
  parameter int DEPTH  = 4,
  localparam int WORDS = 1 << ADDR_W,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // park a reader on a word
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_word_i,
  input  logic [TAG_W-1:0]  push_tag_i,
  output logic              avail_o,
  // list lookup and detach
  input  logic [ADDR_W-1:0] q_word_i,
  output logic              q_has_o,
  output logic [PTR_W-1:0]  q_head_o,
  input  logic              take_i,
  // range release
  input  logic [WORDS-1:0]  clr_mask_i,
  // walk and free one entry
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              rd_more_o,
  output logic [PTR_W-1:0]  rd_next_o,
  input  logic              pop_i
);
  logic [DEPTH-1:0]  ent_vld_q;
  logic [DEPTH-1:0]  ent_more_q;
  logic [TAG_W-1:0]  ent_tag_q  [DEPTH];
  logic [PTR_W-1:0]  ent_next_q [DEPTH];
  logic [ADDR_W-1:0] ent_word_q [DEPTH];

  logic [WORDS-1:0]  lst_vld_q;
  logic [PTR_W-1:0]  lst_head_q [WORDS];
  logic [PTR_W-1:0]  lst_tail_q [WORDS];

  logic [PTR_W-1:0]  free_ptr;
  logic              free_any;

  // lowest free entry
  always_comb begin
    free_ptr = '0;
    free_any = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_vld_q[i]) begin
        free_ptr = PTR_W'(i);
        free_any = 1'b1;
      end
    end
  end

  assign avail_o = free_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_vld_q  <= '0;
      ent_more_q <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        ent_tag_q[e]  <= '0;
        ent_next_q[e] <= '0;
        ent_word_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (ent_vld_q[e] && clr_mask_i[ent_word_q[e]]) ent_vld_q[e] <= 1'b0;
        if (pop_i && rd_ptr_i == PTR_W'(e))           ent_vld_q[e] <= 1'b0;
        if (push_i && free_ptr == PTR_W'(e)) begin
          ent_vld_q[e]  <= 1'b1;
          ent_more_q[e] <= 1'b0;
          ent_tag_q[e]  <= push_tag_i;
          ent_word_q[e] <= push_word_i;
        end
        // link the old tail to the new entry
        if (push_i && lst_vld_q[push_word_i] && lst_tail_q[push_word_i] == PTR_W'(e)) begin
          ent_more_q[e] <= 1'b1;
          ent_next_q[e] <= free_ptr;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lst_vld_q <= '0;
      for (int w = 0; w < WORDS; w++) begin
        lst_head_q[w] <= '0;
        lst_tail_q[w] <= '0;
      end
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (clr_mask_i[w] || (take_i && q_word_i == ADDR_W'(w))) begin
          lst_vld_q[w] <= 1'b0;
        end else if (push_i && push_word_i == ADDR_W'(w)) begin
          lst_tail_q[w] <= free_ptr;
          if (!lst_vld_q[w]) begin
            lst_vld_q[w]  <= 1'b1;
            lst_head_q[w] <= free_ptr;
          end
        end
      end
    end
  end

  assign q_has_o   = lst_vld_q[q_word_i];
  assign q_head_o  = lst_head_q[q_word_i];
  assign rd_tag_o  = ent_tag_q[rd_ptr_i];
  assign rd_more_o = ent_more_q[rd_ptr_i];
  assign rd_next_o = ent_next_q[rd_ptr_i];
endmodule

// File: rtl/isq_resp_stage.sv
module isq_resp_stage #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] data_o,
  output logic              free_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      tag_o   <= tag_i;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assign free_o = !valid_o || ready_i;
endmodule

// File: rtl/isq_mem.sv
module isq_mem
  import isq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 16,
  parameter int TAG_W      = 4,
  parameter int POOL_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [ADDR_W:0]   req_cnt_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              resp_valid_o,
  input  logic              resp_ready_i,
  output logic [TAG_W-1:0]  resp_tag_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              err_o
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int PTR_W = (POOL_DEPTH > 1) ? $clog2(POOL_DEPTH) : 1;
  localparam int RW    = ADDR_W + 2;

  isq_op_e           op;
  logic              fire, rd_hit, rd_miss, wr_ok, wr_bad, al;
  logic              word_full;
  logic [DATA_W-1:0] word_data;
  logic              pool_avail, q_has, rd_more;
  logic [PTR_W-1:0]  q_head, rd_next;
  logic [TAG_W-1:0]  rd_tag;
  logic              resp_free, resp_load, drain_step;
  logic [TAG_W-1:0]  load_tag;
  logic [DATA_W-1:0] load_data;
  logic [WORDS-1:0]  clr_mask;
  logic [RW-1:0]     rng_lo, rng_hi;

  logic              drain_q;
  logic [PTR_W-1:0]  drain_ptr_q;
  logic [DATA_W-1:0] drain_data_q;
  logic              err_q;

  assign op = isq_op_e'(req_op_i);

  always_comb begin
    if (drain_q) begin
      req_ready_o = 1'b0;
    end else begin
      unique case (op)
        OP_READ: req_ready_o = word_full ? resp_free : pool_avail;
        default: req_ready_o = 1'b1;
      endcase
    end
  end

  assign fire    = req_valid_i && req_ready_o;
  assign rd_hit  = fire && (op == OP_READ)  &&  word_full;
  assign rd_miss = fire && (op == OP_READ)  && !word_full;
  assign wr_ok   = fire && (op == OP_WRITE) && !word_full;
  assign wr_bad  = fire && (op == OP_WRITE) &&  word_full;
  assign al      = fire && (op == OP_ALLOC);

  // allocate range decode, clipped at the top word
  assign rng_lo = RW'(req_addr_i);
  assign rng_hi = rng_lo + RW'(req_cnt_i);

  for (genvar w = 0; w < WORDS; w++) begin : g_rng
    assign clr_mask[w] = al && (RW'(w) >= rng_lo) && (RW'(w) < rng_hi);
  end

  assign drain_step = drain_q && resp_free;
  assign resp_load  = rd_hit || drain_step;
  assign load_tag   = drain_q ? rd_tag       : req_tag_i;
  assign load_data  = drain_q ? drain_data_q : word_data;

  isq_presence #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pres (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (wr_ok),
    .wr_addr_i  (req_addr_i),
    .wr_data_i  (req_data_i),
    .clr_mask_i (clr_mask),
    .rd_addr_i  (req_addr_i),
    .rd_full_o  (word_full),
    .rd_data_o  (word_data)
  );

  isq_defer_pool #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .DEPTH(POOL_DEPTH)) u_pool (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (rd_miss),
    .push_word_i (req_addr_i),
    .push_tag_i  (req_tag_i),
    .avail_o     (pool_avail),
    .q_word_i    (req_addr_i),
    .q_has_o     (q_has),
    .q_head_o    (q_head),
    .take_i      (wr_ok),
    .clr_mask_i  (clr_mask),
    .rd_ptr_i    (drain_ptr_q),
    .rd_tag_o    (rd_tag),
    .rd_more_o   (rd_more),
    .rd_next_o   (rd_next),
    .pop_i       (drain_step)
  );

  isq_resp_stage #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_resp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (resp_load),
    .tag_i   (load_tag),
    .data_i  (load_data),
    .ready_i (resp_ready_i),
    .valid_o (resp_valid_o),
    .tag_o   (resp_tag_o),
    .data_o  (resp_data_o),
    .free_o  (resp_free)
  );

  // delivery walker over one word's parked list
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drain_q      <= 1'b0;
      drain_ptr_q  <= '0;
      drain_data_q <= '0;
    end else if (wr_ok && q_has) begin
      drain_q      <= 1'b1;
      drain_ptr_q  <= q_head;
      drain_data_q <= req_data_i;
    end else if (drain_step) begin
      if (rd_more) drain_ptr_q <= rd_next;
      else         drain_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= wr_bad;
  end

  assign err_o = err_q;
endmodule

// File: rtl/isq_mem_chk.sv
module isq_mem_chk #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [1:0]        req_op_i,
  input logic [TAG_W-1:0]  req_tag_i,
  input logic              resp_valid_o,
  input logic              resp_ready_i,
  input logic [TAG_W-1:0]  resp_tag_o,
  input logic [DATA_W-1:0] resp_data_o,
  input logic              err_o,
  input logic              drain_q,
  input logic              pool_avail,
  input logic              word_full
);
  assert_hit_resp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_op_i == 2'd0 && word_full
    |=> resp_valid_o && resp_tag_o == $past(req_tag_i));

  assert_miss_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_op_i == 2'd0 && !word_full && !drain_q && !resp_valid_o
    |=> !resp_valid_o);

  assert_drain_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_q |-> !req_ready_o);

  assert_err_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_valid_i && req_ready_o && req_op_i == 2'd1));

  assert_pool_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_op_i == 2'd0 && !word_full && !pool_avail |-> !req_ready_o);

  assert_resp_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_ready_i
    |=> resp_valid_o && $stable(resp_tag_o) && $stable(resp_data_o));
endmodule

bind isq_mem isq_mem_chk #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_op_i     (req_op_i),
  .req_tag_i    (req_tag_i),
  .resp_valid_o (resp_valid_o),
  .resp_ready_i (resp_ready_i),
  .resp_tag_o   (resp_tag_o),
  .resp_data_o  (resp_data_o),
  .err_o        (err_o),
  .drain_q      (drain_q),
  .pool_avail   (pool_avail),
  .word_full    (word_full)
);

// File: tb/sim_isq_mem.sv
`timescale 1ns/1ps
module sim_isq_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [3:0]  req_addr = '0;
  logic [4:0]  req_cnt = '0;
  logic [3:0]  req_tag = '0;
  logic [15:0] req_data = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic [3:0]  resp_tag;
  logic [15:0] resp_data;
  logic        err;

  int n_chk = 0;
  int n_fail = 0;
  logic [19:0] exp_q [$];
  string       exp_r [$];

  always #10 clk = ~clk;

  isq_mem u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_cnt_i(req_cnt), .req_tag_i(req_tag), .req_data_i(req_data),
    .resp_valid_o(resp_valid), .resp_ready_i(resp_ready),
    .resp_tag_o(resp_tag), .resp_data_o(resp_data), .err_o(err)
  );

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic expect_resp(input logic [3:0] t, input logic [15:0] d, input string r);
    exp_q.push_back({t, d});
    exp_r.push_back(r);
  endtask

  // called just after a rising edge; returns just after the accepting edge
  task automatic send(input logic [1:0] op, input logic [3:0] a, input logic [4:0] c,
                      input logic [3:0] t, input logic [15:0] d);
    req_op = op; req_addr = a; req_cnt = c; req_tag = t; req_data = d;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: a transfer seen mid-cycle completes at the next edge
  always @(negedge clk) begin
    if (rst_n && resp_valid && resp_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R4 R9 unexpected response: actual tag=%0h data=%0h expected none",
                 resp_tag, resp_data);
      end else begin
        logic [19:0] e;
        string r;
        e = exp_q.pop_front();
        r = exp_r.pop_front();
        if ({resp_tag, resp_data} !== e) begin
          n_fail++;
          $display("FAIL %s response: actual=%0h expected=%0h", r, {resp_tag, resp_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired: actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] held_tag;
    // R1 reset state
    repeat (2) @(negedge clk);
    chk(resp_valid == 1'b0, "R1", "resp_valid in reset", int'(resp_valid), 0);
    chk(err == 1'b0, "R1", "err in reset", int'(err), 0);
    chk(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(1);

    // R4 read of empty word parks silently
    send(2'd0, 4'd3, 5'd0, 4'd1, 16'h0);
    @(negedge clk);
    chk(resp_valid == 1'b0, "R4", "no response after miss", int'(resp_valid), 0);
    @(negedge clk);
    chk(resp_valid == 1'b0, "R4", "no response two cycles on", int'(resp_valid), 0);
    @(posedge clk); #1;
    send(2'd0, 4'd3, 5'd0, 4'd2, 16'h0);
    send(2'd0, 4'd5, 5'd0, 4'd3, 16'h0);

    // R5 R6 write wakes parked readers in order
    expect_resp(4'd1, 16'hA5A5, "R5");
    expect_resp(4'd2, 16'hA5A5, "R5");
    send(2'd1, 4'd3, 5'd0, 4'd0, 16'hA5A5);
    @(negedge clk);
    chk(resp_valid == 1'b0, "R5", "no response one edge after write", int'(resp_valid), 0);
    chk(req_ready == 1'b0, "R6", "ready low while delivering", int'(req_ready), 0);
    @(negedge clk);
    chk(resp_valid == 1'b1, "R5", "first wake response timing", int'(resp_valid), 1);
    chk(req_ready == 1'b0, "R6", "ready low on second delivery", int'(req_ready), 0);
    idle(3);

    // R2 R3 read of full word
    expect_resp(4'd7, 16'hA5A5, "R3");
    send(2'd0, 4'd3, 5'd0, 4'd7, 16'h0);
    @(negedge clk);
    chk(resp_valid == 1'b1, "R3", "hit response next cycle", int'(resp_valid), 1);
    chk(resp_data == 16'hA5A5, "R2", "stored data returned", int'(resp_data), 16'hA5A5);
    @(posedge clk); #1;

    // R7 second write to full word
    send(2'd1, 4'd3, 5'd0, 4'd0, 16'h1234);
    @(negedge clk);
    chk(err == 1'b1, "R7", "err pulse", int'(err), 1);
    @(negedge clk);
    chk(err == 1'b0, "R7", "err one cycle only", int'(err), 0);
    @(posedge clk); #1;
    expect_resp(4'd8, 16'hA5A5, "R7");
    send(2'd0, 4'd3, 5'd0, 4'd8, 16'h0);
    idle(2);

    // R8 allocate range
    send(2'd1, 4'd8, 5'd0, 4'd0, 16'h0808);
    send(2'd1, 4'd9, 5'd0, 4'd0, 16'h0909);
    send(2'd1, 4'd10, 5'd0, 4'd0, 16'h0A0A);
    send(2'd2, 4'd8, 5'd2, 4'd0, 16'h0);
    expect_resp(4'd9, 16'h0A0A, "R8");
    send(2'd0, 4'd10, 5'd0, 4'd9, 16'h0);
    send(2'd0, 4'd9, 5'd0, 4'd10, 16'h0);
    expect_resp(4'd10, 16'h9999, "R8");
    send(2'd1, 4'd9, 5'd0, 4'd0, 16'h9999);
    idle(3);
    send(2'd1, 4'd8, 5'd0, 4'd0, 16'h8888);
    @(negedge clk);
    chk(err == 1'b0, "R8", "rewrite of emptied word no error", int'(err), 0);
    @(posedge clk); #1;
    send(2'd2, 4'd10, 5'd0, 4'd0, 16'h0);
    expect_resp(4'd11, 16'h0A0A, "R8");
    send(2'd0, 4'd10, 5'd0, 4'd11, 16'h0);
    idle(2);

    // R9 allocate drops the reader parked on word 5
    send(2'd2, 4'd5, 5'd1, 4'd0, 16'h0);
    send(2'd1, 4'd5, 5'd0, 4'd0, 16'h5555);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(resp_valid == 1'b0, "R9", "no response for released reader", int'(resp_valid), 0);
    end
    @(posedge clk); #1;

    // R10 fill the pool, then a miss stalls
    for (int i = 1; i <= 4; i++) send(2'd0, 4'd12, 5'd0, 4'(i), 16'h0);
    req_op = 2'd0; req_addr = 4'd13; req_tag = 4'd5; req_valid = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R10", "ready low with pool exhausted", int'(req_ready), 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    expect_resp(4'd6, 16'hA5A5, "R10");
    send(2'd0, 4'd3, 5'd0, 4'd6, 16'h0);
    idle(2);

    // R11 back-pressure during delivery
    resp_ready = 1'b0;
    for (int i = 1; i <= 4; i++) expect_resp(4'(i), 16'h0C0C, "R5 R11");
    send(2'd1, 4'd12, 5'd0, 4'd0, 16'h0C0C);
    @(negedge clk);
    @(negedge clk);
    chk(resp_valid == 1'b1, "R11", "response pending", int'(resp_valid), 1);
    held_tag = resp_tag;
    @(negedge clk);
    chk(resp_valid == 1'b1, "R11", "response held", int'(resp_valid), 1);
    chk(resp_tag == held_tag, "R11", "tag held", int'(resp_tag), int'(held_tag));
    @(posedge clk); #1;
    resp_ready = 1'b1;
    idle(10);
    chk(exp_q.size() == 0, "R5", "all expected responses seen", exp_q.size(), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule